// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block keeps a short run of instructions for each recently seen branch target, so that a taken branch does not have to wait for memory. It is consulted only when a branch is actually taken; it makes no guess about branch outcome. The fetch unit raises a taken-branch strobe with the target address. On a hit, the block issues the stored instructions one per cycle, and these fill the slots after the single delay slot. Meanwhile the fetch unit refetches from memory starting just beyond the cached run. On a miss, the block takes the next instructions that memory returns for that target from the fill port and keeps them for the next time.

The cache is direct-mapped with a tag compare. The default build has 32 entries of four 32-bit words, which is 512 bytes. A second useful build has 128 entries of two words, which is 1024 bytes. A global invalidate drops every entry in one cycle.

Top module: `branch_target_cache`

## Requirements
- R1: After reset, `outValid`, `hitPulse` and `missPulse` are low, and every entry is invalid, so the first lookup to any target misses.
- R2: A `brTaken` with `invalidate` low whose entry is valid with a matching tag raises `hitPulse` for one cycle in the next cycle. In that same cycle `outValid` rises and stays high for exactly WORDS cycles, with `outInsn` giving the stored words in ascending address order.
- R3: A `brTaken` with `invalidate` low that does not hit raises `missPulse` for one cycle in the next cycle, keeps `outValid` low, and arms a fill of that entry.
- R4: While a fill is armed, each cycle with `fillValid` high stores `fillInsn` as the next word of the entry, starting with the word at the target. Gaps in `fillValid` are allowed. After WORDS words, a later branch to the same target hits and returns them.
- R5: An entry being filled counts as invalid until its last word is stored, so a branch to it after a partial fill misses.
- R6: The entry index is target bits [6:2] and the tag is bits [31:7]. A target with the same index but a different tag misses and replaces the entry.
- R7: `invalidate` clears every entry in one cycle and ends any issue or fill, so `outValid` is low in the next cycle. A `brTaken` in the same cycle is ignored: neither pulse follows.
- R8: A new `brTaken` during an issue or a fill cancels it and starts a fresh lookup. An entry whose fill was cancelled stays invalid.
- R9: `fillValid` has no effect when no fill is armed, or in a cycle where `brTaken` is high. Stored entries stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brTaken | input | 1 | Taken-branch strobe, one cycle per branch |
| brTarget | input | ADDR_W | Branch target byte address, word aligned |
| invalidate | input | 1 | Clears every entry |
| fillValid | input | 1 | A fill word is present on `fillInsn` |
| fillInsn | input | INSN_W | Instruction word returned by memory |
| outValid | output | 1 | `outInsn` carries a cached instruction |
| outInsn | output | INSN_W | Cached instruction, zero when not valid |
| hitPulse | output | 1 | Lookup of the previous cycle hit |
| missPulse | output | 1 | Lookup of the previous cycle missed |

## Verification
Every lookup result is due exactly one cycle after the edge that samples `brTaken`. In that cycle `hitPulse` or `missPulse` is high, and on a hit the first word is already on `outInsn`. Word k of an issue appears k cycles later. An entry filled by its last `fillValid` can be hit by a branch sampled in the very next cycle. The bench drives inputs on the falling edge and advances its queue-based model on the rising edge. It compares all outputs at the next falling edge, so every expectation is taken in the one cycle where its result is due.

// File: rtl/btc_pkg.sv
package btc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FILL  = 2'd2
  } btcState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch lookup index for the run that follows
    logic startIssue;  // lookup hit, begin issuing
    logic startFill;   // lookup missed, drop entry and write new tag
    logic writeWord;   // store fill word at current position
    logic commit;      // last word stored, mark entry valid
    logic clearAll;    // drop every entry
  } btcStrobes_t;

endpackage

// File: rtl/btc_ctrl.sv
module btc_ctrl
  import btc_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brTaken,
  input  logic             invalidate,
  input  logic             fillValid,
  input  logic             lookupHit,
  output btcStrobes_t      strb,
  output logic [CNT_W-1:0] wordSel,
  output logic             issueActive,
  output logic             hitPulse,
  output logic             missPulse
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  btcState_e        state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strb            = '0;
    strb.clearAll   = invalidate;
    strb.capture    = brTaken && !invalidate;
    strb.startIssue = brTaken && !invalidate && lookupHit;
    strb.startFill  = brTaken && !invalidate && !lookupHit;
    // a fill word arriving with a new branch belongs to the cancelled run
    strb.writeWord  = (state == ST_FILL) && fillValid && !brTaken && !invalidate;
    strb.commit     = (state == ST_FILL) && fillValid && !brTaken && !invalidate
                      && (cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      hitPulse  <= 1'b0;
      missPulse <= 1'b0;
    end else begin
      hitPulse  <= strb.startIssue;
      missPulse <= strb.startFill;
      if (invalidate) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (brTaken) begin
        state <= lookupHit ? ST_ISSUE : ST_FILL;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_ISSUE: begin
            if (cnt == LAST) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_FILL: begin
            if (fillValid) begin
              if (cnt == LAST) begin
                state <= ST_IDLE;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: begin
            state <= ST_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  assign wordSel     = cnt;
  assign issueActive = (state == ST_ISSUE);

endmodule

// File: rtl/btc_dpath.sv
module btc_dpath
  import btc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSN_W  = 32,
  parameter int ENTRIES = 32,
  parameter int WORDS   = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int OFF_W  = $clog2(INSN_W / 8),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int CNT_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  btcStrobes_t       strb,
  input  logic [CNT_W-1:0]  wordSel,
  input  logic              issueActive,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic [INSN_W-1:0] fillInsn,
  output logic              lookupHit,
  output logic [INSN_W-1:0] outInsn
);

  logic [IDX_W-1:0]  lkIdx;
  logic [TAG_W-1:0]  lkTag;
  logic [IDX_W-1:0]  curIdx;
  logic [ENTRIES-1:0] validVec;
  logic [TAG_W-1:0]  tagArr  [ENTRIES];
  logic [INSN_W-1:0] dataArr [ENTRIES][WORDS];

  assign lkIdx     = brTarget[OFF_W +: IDX_W];
  assign lkTag     = brTarget[ADDR_W-1 -: TAG_W];
  assign lookupHit = validVec[lkIdx] && (tagArr[lkIdx] == lkTag);

  always_ff @(posedge clk) begin
    if (!rstN)             curIdx <= '0;
    else if (strb.capture) curIdx <= lkIdx;
  end

  always_ff @(posedge clk) begin
    if (strb.startFill) tagArr[lkIdx] <= lkTag;
  end

  always_ff @(posedge clk) begin
    if (strb.writeWord) dataArr[curIdx][wordSel] <= fillInsn;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rstN)
        validVec[e] <= 1'b0;
      else if (strb.clearAll)
        validVec[e] <= 1'b0;
      else if (strb.startFill && (lkIdx == IDX_W'(e)))
        validVec[e] <= 1'b0;
      else if (strb.commit && (curIdx == IDX_W'(e)))
        validVec[e] <= 1'b1;
    end
  end

  assign outInsn = issueActive ? dataArr[curIdx][wordSel] : '0;

endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
  import btc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSN_W  = 32,
  parameter int ENTRIES = 32,
  parameter int WORDS   = 4,
  localparam int CNT_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              brTaken,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              invalidate,
  input  logic              fillValid,
  input  logic [INSN_W-1:0] fillInsn,
  output logic              outValid,
  output logic [INSN_W-1:0] outInsn,
  output logic              hitPulse,
  output logic              missPulse
);

  btcStrobes_t      strb;
  logic [CNT_W-1:0] wordSel;
  logic             lookupHit;

  btc_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .brTaken    (brTaken),
    .invalidate (invalidate),
    .fillValid  (fillValid),
    .lookupHit  (lookupHit),
    .strb       (strb),
    .wordSel    (wordSel),
    .issueActive(outValid),
    .hitPulse   (hitPulse),
    .missPulse  (missPulse)
  );

  btc_dpath #(
    .ADDR_W (ADDR_W),
    .INSN_W (INSN_W),
    .ENTRIES(ENTRIES),
    .WORDS  (WORDS)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wordSel    (wordSel),
    .issueActive(outValid),
    .brTarget   (brTarget),
    .fillInsn   (fillInsn),
    .lookupHit  (lookupHit),
    .outInsn    (outInsn)
  );

endmodule

// File: rtl/btc_chk.sv
module btc_chk #(
  parameter int WORDS = 4
) (
  input logic clk,
  input logic rstN,
  input logic brTaken,
  input logic invalidate,
  input logic outValid,
  input logic hitPulse,
  input logic missPulse
);

  int runLen;

  always_ff @(posedge clk) begin
    if (!rstN)         runLen <= 0;
    else if (hitPulse) runLen <= 1;
    else if (outValid) runLen <= runLen + 1;
    else               runLen <= 0;
  end

  // R2: a lookup yields a hit or a miss, never both
  p_one_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(hitPulse && missPulse));

  // R2: a hit starts the issue in the same cycle
  p_hit_issues_r2: assert property (@(posedge clk) disable iff (!rstN)
    hitPulse |-> outValid);

  // R2: issue begins only with a hit
  p_issue_needs_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> hitPulse);

  // R2: no run is longer than one entry
  p_run_bounded_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !hitPulse) |-> (runLen < WORDS));

  // R3: every accepted branch gets a result in the next cycle
  p_branch_answered_r3: assert property (@(posedge clk) disable iff (!rstN)
    (brTaken && !invalidate) |=> (hitPulse || missPulse));

  // R3: results only follow a branch
  p_result_after_branch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hitPulse || missPulse) |-> $past(brTaken));

  // R7: invalidate silences the block in the next cycle
  p_invalidate_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    invalidate |=> (!outValid && !hitPulse && !missPulse));

endmodule

bind branch_target_cache btc_chk #(.WORDS(WORDS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .brTaken   (brTaken),
  .invalidate(invalidate),
  .outValid  (outValid),
  .hitPulse  (hitPulse),
  .missPulse (missPulse)
);

// File: tb/sim_branch_target_cache.sv
`timescale 1ns/1ps
module sim_branch_target_cache;

  localparam int ENTRIES = 32;
  localparam int WORDS   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        brTaken = 1'b0;
  logic [31:0] brTarget = '0;
  logic        invalidate = 1'b0;
  logic        fillValid = 1'b0;
  logic [31:0] fillInsn = '0;
  logic        outValid;
  logic [31:0] outInsn;
  logic        hitPulse;
  logic        missPulse;

  always #2 clk = ~clk;

  branch_target_cache u0 (
    .clk(clk), .rstN(rstN), .brTaken(brTaken), .brTarget(brTarget),
    .invalidate(invalidate), .fillValid(fillValid), .fillInsn(fillInsn),
    .outValid(outValid), .outInsn(outInsn), .hitPulse(hitPulse),
    .missPulse(missPulse)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference: entry table plus queue of words still to issue
  bit          mValid [ENTRIES];
  int unsigned mTag   [ENTRIES];
  logic [31:0] mData  [int];
  logic [31:0] issueQ [$];
  bit          filling;
  int          fIdx, fCnt;
  bit          expHit, expMiss;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) mValid[i] = 0;
      issueQ.delete();
      filling = 0; expHit = 0; expMiss = 0;
    end else begin
      expHit = 0; expMiss = 0;
      if (invalidate) begin
        for (int i = 0; i < ENTRIES; i++) mValid[i] = 0;
        issueQ.delete();
        filling = 0;
      end else if (brTaken) begin
        int idx;
        int unsigned tg;
        idx = int'((brTarget >> 2) % ENTRIES);
        tg  = brTarget >> 7;
        issueQ.delete();
        filling = 0;
        if (mValid[idx] && mTag[idx] == tg) begin
          expHit = 1;
          for (int w = 0; w < WORDS; w++) issueQ.push_back(mData[idx*WORDS+w]);
        end else begin
          expMiss = 1;
          mValid[idx] = 0;
          mTag[idx] = tg;
          filling = 1; fIdx = idx; fCnt = 0;
        end
      end else begin
        if (issueQ.size() > 0) void'(issueQ.pop_front());
        if (filling && fillValid) begin
          mData[fIdx*WORDS+fCnt] = fillInsn;
          fCnt++;
          if (fCnt == WORDS) begin
            mValid[fIdx] = 1;
            filling = 0;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    bit ev;
    ev = (issueQ.size() > 0);
    check(outValid == ev, curReq, "outValid", 32'(outValid), 32'(ev));
    if (ev) check(outInsn == issueQ[0], curReq, "outInsn", outInsn, issueQ[0]);
    check(hitPulse == expHit, curReq, "hitPulse", 32'(hitPulse), 32'(expHit));
    check(missPulse == expMiss, curReq, "missPulse", 32'(missPulse), 32'(expMiss));
  endtask

  // one clock: inputs applied now, results compared at next falling edge
  task automatic cyc(input bit b, input logic [31:0] t, input bit inv,
                     input bit fv, input logic [31:0] fi);
    brTaken = b; brTarget = t; invalidate = inv; fillValid = fv; fillInsn = fi;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, '0);
  endtask

  task automatic branch(input logic [31:0] t);
    cyc(1, t, 0, 0, '0);
  endtask

  task automatic fillRun(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 1, base + 32'(i));
  endtask

  localparam logic [31:0] TA = 32'h0000_0100; // index 0
  localparam logic [31:0] TB = 32'h0000_0180; // index 0, other tag (R6)
  localparam logic [31:0] TC = 32'h0000_2044; // index 17

  initial begin
    #(4 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    check(!outValid && !hitPulse && !missPulse, "R1", "outputs after reset",
          {29'd0, outValid, hitPulse, missPulse}, 32'd0);
    compareAll();

    // R1/R3: first lookup misses
    curReq = "R3";
    branch(TA);
    check(missPulse == 1'b1, "R3", "cold miss", 32'(missPulse), 32'd1);
    // R4: fill with a gap
    curReq = "R4";
    fillRun(32'hA000_0000, 2);
    idle(1);
    fillRun(32'hA000_0002, 2);
    // R2: hit returns the four words in order
    curReq = "R2";
    branch(TA);
    check(hitPulse == 1'b1 && outInsn == 32'hA000_0000, "R2", "first hit word",
          outInsn, 32'hA000_0000);
    idle(WORDS + 1);

    // R6: same index other tag misses and replaces
    curReq = "R6";
    branch(TB);
    check(missPulse == 1'b1, "R6", "tag mismatch miss", 32'(missPulse), 32'd1);
    // R5: partial fill keeps entry invalid
    curReq = "R5";
    fillRun(32'hB000_0000, 2);
    branch(TB);
    check(missPulse == 1'b1, "R5", "partial fill miss", 32'(missPulse), 32'd1);
    fillRun(32'hB100_0000, WORDS);
    curReq = "R6";
    branch(TA);
    check(missPulse == 1'b1, "R6", "replaced entry miss", 32'(missPulse), 32'd1);
    fillRun(32'hA200_0000, WORDS);
    branch(TA);
    idle(WORDS);

    // R8: branch during issue restarts, cancelled fill stays invalid
    curReq = "R8";
    branch(TC);
    fillRun(32'hC000_0000, WORDS);
    branch(TA);
    idle(1);
    branch(TC);
    check(hitPulse == 1'b1 && outInsn == 32'hC000_0000, "R8", "restart hit",
          outInsn, 32'hC000_0000);
    branch(TB);
    fillRun(32'hB300_0000, 1);
    branch(TA);
    idle(2);
    branch(TB);
    check(missPulse == 1'b1, "R8", "cancelled fill invalid", 32'(missPulse), 32'd1);
    fillRun(32'hB400_0000, WORDS);

    // R9: stray fill words are ignored
    curReq = "R9";
    fillRun(32'hDEAD_0000, 3);
    branch(TB);
    check(outInsn == 32'hB400_0000, "R9", "entry unchanged", outInsn, 32'hB400_0000);
    idle(WORDS);
    branch(TC);
    cyc(1, TC, 0, 1, 32'hEEEE_0000);
    check(hitPulse == 1'b1 && outInsn == 32'hC000_0000, "R9", "fill with branch dropped",
          outInsn, 32'hC000_0000);
    idle(WORDS);

    // R7: invalidate during issue, invalidate with branch, then all miss
    curReq = "R7";
    branch(TC);
    idle(1);
    cyc(0, '0, 1, 0, '0);
    check(outValid == 1'b0, "R7", "issue stopped", 32'(outValid), 32'd0);
    cyc(1, TB, 1, 0, '0);
    check(!hitPulse && !missPulse, "R7", "branch with invalidate ignored",
          {30'd0, hitPulse, missPulse}, 32'd0);
    branch(TB);
    check(missPulse == 1'b1, "R7", "miss after invalidate", 32'(missPulse), 32'd1);
    fillRun(32'hF000_0000, 2);
    cyc(0, '0, 1, 0, '0);
    fillRun(32'hF000_0002, 2);
    branch(TB);
    check(missPulse == 1'b1, "R7", "fill aborted by invalidate", 32'(missPulse), 32'd1);
    fillRun(32'hF100_0000, WORDS);
    branch(TB);
    idle(WORDS + 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule